// File: doc/BRIEF.md
# Programmable Tick Divider with Deferred Divisor Update

This block divides the system clock by a programmable ratio and emits a single-cycle tick once per division period. It is meant to sit on one direction (transmit or receive) of an infrared link, where the tick paces bit or sample timing. Software loads a 16-bit divisor value `D` through a write strobe. The tick period is then `D + 1` clock cycles, so ratios run from 2 up to 65536.

A function-enable input sets how a new divisor is applied. While the path is idle, a write takes effect on the next clock edge. While the path is running, the written value is parked and replaces the active divisor only when the internal down-counter next reaches zero. This means a period in progress is never cut short or stretched. The written value can be read back as a zero-extended 32-bit word. All pins are plain control and status signals. There is no streamed data path, so no valid/ready handshake applies.

Top module: `ir_tick_divider`

## Requirements
- R1: While `func_en` is high, with active divisor D, `tick` pulses every D+1 clock cycles. After `func_en` rises, the first tick appears D+1 cycles after the first enabled edge.
- R2: `tick` is never high for two consecutive cycles.
- R3: While `func_en` is low, a write (`wr_en` high) sets `active_div` to the written value on the next clock edge.
- R4: A written value of 0 is reserved and is used as 1, giving a ratio of 2 and never a divide-by-one.
- R5: While `func_en` is low, no tick is produced, and the counter is held at the active divisor so a restart begins a full period.
- R6: While `func_en` is high, a write leaves `active_div` unchanged until the counter reaches zero. The period in progress completes with the old divisor, and later periods use the new one.
- R7: `rd_data` returns the last raw written value zero-extended to 32 bits, with bits 31:16 equal to 0. The value is 1 after reset.
- R8: A value still pending when `func_en` drops is applied to `active_div` on the next edge.
- R9: A divisor of 65535 gives a tick period of 65536 cycles.
- R10: After reset, `tick` is 0 and `active_div` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Divisor write strobe, one cycle per write |
| wr_data | input | 16 | Divisor value D written with `wr_en` |
| func_en | input | 1 | Path enable; high runs the divider |
| tick | output | 1 | One-cycle pulse at each counter zero |
| active_div | output | 16 | Divisor currently used for reloads |
| rd_data | output | 32 | Readback of last written value, zero-extended |

## Verification
The hardest case to reach is a write that lands partway through a running period. The stimulus must show that the current period still ends with the old ratio and that the following periods use the new one. To get there, the bench runs the divider at a small ratio and waits for a tick. It then issues the write two cycles into the next period and checks `active_div` before the counter reaches zero. A similar sequence drops `func_en` while a value is still pending, to observe the flush to the idle path.

// File: rtl/ir_tick_divider_pkg.sv
package ir_tick_divider_pkg;
  localparam int unsigned DIV_W_DEF = 16;
  localparam int unsigned BUS_W_DEF = 32;

  // source of the divisor taken on the next edge
  typedef enum logic [1:0] {
    SRC_KEEP  = 2'd0,
    SRC_WRITE = 2'd1,
    SRC_PEND  = 2'd2
  } div_src_e;
endpackage

// File: rtl/ir_div_shadow.sv
module ir_div_shadow
  import ir_tick_divider_pkg::*;
#(
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned BUS_W     = BUS_W_DEF,
  parameter int unsigned RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             run,
  input  logic             reload,
  output logic [DIV_W-1:0] active_div,
  output logic [DIV_W-1:0] next_div,
  output logic [BUS_W-1:0] rd_data
);
  localparam int unsigned PAD_W = BUS_W - DIV_W;
  localparam logic [DIV_W-1:0] INIT_DIV = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] active_q, pend_val_q, raw_q, wr_fixed;
  logic             pend_q, apply;
  div_src_e         src;

  // a reserved zero is promoted to the smallest legal divisor
  assign wr_fixed = (wr_data == '0) ? DIV_W'(1) : wr_data;
  // idle path or counter at zero: the divisor may change now
  assign apply    = !run || reload;

  always_comb begin
    src = SRC_KEEP;
    if (apply) begin
      if (wr_en)       src = SRC_WRITE;
      else if (pend_q) src = SRC_PEND;
    end
  end

  always_comb begin
    case (src)
      SRC_WRITE: next_div = wr_fixed;
      SRC_PEND:  next_div = pend_val_q;
      default:   next_div = active_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q   <= INIT_DIV;
      pend_val_q <= INIT_DIV;
      raw_q      <= INIT_DIV;
      pend_q     <= 1'b0;
    end else begin
      active_q <= next_div;
      if (wr_en) raw_q <= wr_data;
      if (apply) begin
        pend_q <= 1'b0;
      end else if (wr_en) begin
        pend_q     <= 1'b1;
        pend_val_q <= wr_fixed;
      end
    end
  end

  assign active_div = active_q;
  assign rd_data    = {{PAD_W{1'b0}}, raw_q};
endmodule

// File: rtl/ir_div_counter.sv
module ir_div_counter #(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] load_div,
  output logic             reload,
  output logic             tick
);
  localparam logic [DIV_W-1:0] INIT_CNT = DIV_W'(RESET_DIV);

  logic [DIV_W-1:0] count_q;
  logic             tick_q;

  assign reload = run && (count_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= INIT_CNT;
      tick_q  <= 1'b0;
    end else begin
      // idle: track the divisor; running: reload at zero
      if (!run || reload) count_q <= load_div;
      else                count_q <= count_q - DIV_W'(1);
      tick_q <= reload;
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/ir_tick_divider.sv
module ir_tick_divider
  import ir_tick_divider_pkg::*;
#(
  parameter int unsigned DIV_W     = DIV_W_DEF,
  parameter int unsigned BUS_W     = BUS_W_DEF,
  parameter int unsigned RESET_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_data,
  input  logic             func_en,
  output logic             tick,
  output logic [DIV_W-1:0] active_div,
  output logic [BUS_W-1:0] rd_data
);
  logic             reload;
  logic [DIV_W-1:0] next_div;

  ir_div_shadow #(
    .DIV_W    (DIV_W),
    .BUS_W    (BUS_W),
    .RESET_DIV(RESET_DIV)
  ) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .run       (func_en),
    .reload    (reload),
    .active_div(active_div),
    .next_div  (next_div),
    .rd_data   (rd_data)
  );

  ir_div_counter #(
    .DIV_W    (DIV_W),
    .RESET_DIV(RESET_DIV)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (func_en),
    .load_div(next_div),
    .reload  (reload),
    .tick    (tick)
  );
endmodule

// File: rtl/ir_tick_divider_chk.sv
module ir_tick_divider_chk #(
  parameter int unsigned DIV_W = 16,
  parameter int unsigned BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [DIV_W-1:0] wr_data,
  input logic             func_en,
  input logic             tick,
  input logic [DIV_W-1:0] active_div,
  input logic [BUS_W-1:0] rd_data
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> !tick); // R5

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active_div != '0); // R4

  AST_IDLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!func_en && wr_en) |=>
      active_div == (($past(wr_data) == '0) ? DIV_W'(1) : $past(wr_data))); // R3

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    func_en |=> (tick || active_div == $past(active_div))); // R6

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == BUS_W'($past(wr_data))); // R7
endmodule

bind ir_tick_divider ir_tick_divider_chk #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_chk (.*);

// File: tb/ir_tick_divider_test.sv
`timescale 1ns/1ps
module ir_tick_divider_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        func_en = 1'b0;
  logic        tick;
  logic [15:0] active_div;
  logic [31:0] rd_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // scoreboard: expected tick intervals and the requirement each covers
  int    exp_q[$];
  string tag_q[$];
  longint cyc = 0;
  longint last_cyc = 0;
  bit    have_prev = 1'b0;
  bit    prev_tick = 1'b0;

  ir_tick_divider uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .func_en(func_en), .tick(tick), .active_div(active_div), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tick) begin
        checks++;
        if (prev_tick) begin
          fails++;
          $display("FAIL R2 tick width: got 2+ cycles, expected 1");
        end
        checks++;
        if (exp_q.size() == 0 || !have_prev) begin
          fails++;
          $display("FAIL R5 unexpected tick at cycle %0d, expected none", cyc);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (cyc - last_cyc != longint'(e)) begin
            fails++;
            $display("FAIL %s interval: got %0d, expected %0d", t, cyc - last_cyc, e);
          end
        end
        last_cyc = cyc;
      end
      prev_tick = tick;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h, expected %0h", tag, got, exp);
    end
  endtask

  task automatic expect_iv(input int iv, input string tag);
    exp_q.push_back(iv);
    tag_q.push_back(tag);
  endtask

  task automatic write_div(input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_run();
    @(negedge clk);
    func_en = 1'b1;
    last_cyc = cyc;
    have_prev = 1'b1;
  endtask

  task automatic stop_run();
    wait (exp_q.size() == 0);
    @(negedge clk);
    func_en = 1'b0;
    have_prev = 1'b0;
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_up();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 tick after reset", 32'(tick), 32'd0);
    chk("R10 active_div after reset", 32'(active_div), 32'd1);
    chk("R7 readback after reset", rd_data, 32'd1);

    // idle: no ticks for a while (monitor flags any)
    repeat (20) @(negedge clk);
    chk("R5 idle tick", 32'(tick), 32'd0);

    // idle write applies at once
    write_div(16'd5);
    chk("R3 idle write active_div", 32'(active_div), 32'd5);
    chk("R7 readback 5", rd_data, 32'd5);

    expect_iv(6, "R1"); expect_iv(6, "R1"); expect_iv(6, "R1");
    start_run();
    stop_run();
    chk("R5 divisor held while idle", 32'(active_div), 32'd5);

    // deferred write while running
    write_div(16'd3);
    expect_iv(4, "R1"); expect_iv(4, "R6"); expect_iv(8, "R6"); expect_iv(8, "R6");
    start_run();
    wait (exp_q.size() == 3);
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 16'd7;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R6 active_div held during period", 32'(active_div), 32'd3);
    chk("R7 readback during run", rd_data, 32'd7);
    stop_run();
    chk("R6 new divisor after zero", 32'(active_div), 32'd7);

    // pending value flushed when the path goes idle
    expect_iv(8, "R1");
    start_run();
    wait (exp_q.size() == 0);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = 16'd2;
    @(negedge clk);
    wr_en = 1'b0;
    func_en = 1'b0;
    have_prev = 1'b0;
    @(negedge clk);
    chk("R8 pending applied on disable", 32'(active_div), 32'd2);
    expect_iv(3, "R8"); expect_iv(3, "R8");
    start_run();
    stop_run();

    // reserved zero
    write_div(16'd0);
    chk("R4 zero promoted to 1", 32'(active_div), 32'd1);
    chk("R7 readback raw zero", rd_data, 32'd0);
    expect_iv(2, "R4"); expect_iv(2, "R4"); expect_iv(2, "R4");
    start_run();
    stop_run();

    // maximum ratio
    write_div(16'hFFFF);
    chk("R9 max divisor", 32'(active_div), 32'h0000FFFF);
    chk("R7 upper bits zero", rd_data, 32'h0000FFFF);
    expect_iv(65536, "R9");
    start_run();
    stop_run();

    repeat (10) @(negedge clk);
    chk("R5 no tick after stop", 32'(tick), 32'd0);
    chk("R1 scoreboard drained", 32'(exp_q.size()), 32'd0);
    finish_up();
  end
endmodule